// File: doc/BRIEF.md
# Quad-SPI Serial Clock and Chip-Select Timer

This block makes the serial clock for a quad-SPI flash port from the system clock and owns the chip-select line. A start request opens a command sequence. CSN goes low and SCK runs at the system clock divided by a programmable factor. The shifting logic raises a done input when its last bit has gone out. The sequence then closes at the end of the current SCK period. After that, CSN stays high for a programmable number of whole SCK periods before another sequence may begin. A start that arrives while a sequence or that quiet gap is still in progress is remembered and served as soon as the gap has run out.

For the read path the block gives a one-system-clock sample strobe. It normally lines up with the rising SCK edge, which is half a period after the flash drives data on the falling edge. One configuration bit moves the strobe to the following falling edge, to absorb board and pad delay. The block also turns a memory-size field into an address width, the field value plus one, so up to 32 address bits are covered. All configuration is captured only while the block is idle, so the shifter sees one fixed setup for the whole of a sequence and the gap that follows it.

Top module: `qspi_sck_timing`

## Requirements
- R1: While rst is high and on the first cycle after it, csn is 1 and sck, sample_stb and busy are 0.
- R2: While csn is low, sck has a period of D = cfg_psc+1 system clocks, with cfg_psc = 0 treated as 1 (so D = 2). Each period starts with a low phase and is high for floor(D/2) cycles.
- R3: sck is 0 whenever csn is 1, and it is still 0 in the first cycle that csn is 0.
- R4: seq_done is acted on only in the last cycle of an SCK period. csn rises on the next clock, so a sequence holds exactly as many sck rising edges as had occurred when seq_done was raised, provided seq_done is raised in the cycle of a rising edge.
- R5: Between two sequences csn stays high for at least G·D system clocks, where G is cfg_gap and D is the divisor, both taken from the sequence that just ended. With G = 0 it still stays high for at least 2 clocks.
- R6: A start_req pulse seen while busy is 1 is held. csn then falls exactly G·D+1 clocks after it rose, or 2 clocks when G = 0. busy is 1 whenever csn is 0.
- R7: With cfg_late = 0, sample_stb is a one-clock pulse in exactly the cycles where sck has just risen while csn is low.
- R8: With cfg_late = 1, sample_stb pulses in exactly the cycles where sck has just fallen while csn stays low. The fall at the end of a sequence gives no pulse.
- R9: addr_bits equals cfg_size+1 (1 to 32) for the whole of a sequence.
- R10: Configuration inputs are sampled only while busy is 0. Changing them during a sequence or its gap does not alter the period, strobe edge, addr_bits or gap length in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to open a command sequence |
| seq_done | input | 1 | Shifter has finished; close the sequence at the period end |
| cfg_psc | input | PSC_W | Clock divisor minus one |
| cfg_gap | input | GAP_W | Minimum CSN-high gap in SCK periods |
| cfg_size | input | SIZE_W | Memory-size field; address bits minus one |
| cfg_late | input | 1 | Move the sample strobe to the falling edge |
| sck | output | 1 | Serial clock to the flash |
| csn | output | 1 | Active-low chip select |
| sample_stb | output | 1 | One-clock read sample strobe |
| busy | output | 1 | Sequence or gap in progress |
| addr_bits | output | SIZE_W+1 | Flash address width |

## Verification
Two events can land on the same clock edge. The first is a start request arriving while the closing gap is still counting. The second is the gap counter expiring. The bench provokes this by pulsing start_req immediately after csn rises, across random divisors and gap lengths including zero. It then requires the next falling edge of csn to come exactly G·D+1 clocks after the rise, never earlier and never later. A second overlap is a seq_done that coincides with the edge that ends a period; the bench judges it by counting rising edges per sequence.

// File: rtl/qspi_tim_pkg.sv
package qspi_tim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } tim_state_t;
endpackage

// File: rtl/qspi_cfg_shadow.sv
module qspi_cfg_shadow #(
  parameter int PSC_W  = 8,
  parameter int GAP_W  = 4,
  parameter int SIZE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PSC_W-1:0]  cfg_psc,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              cfg_late,
  output logic [PSC_W-1:0]  div_m1,
  output logic [GAP_W-1:0]  gap_len,
  output logic              late,
  output logic [SIZE_W:0]   addr_bits
);
  localparam logic [PSC_W-1:0] MIN_DIV_M1 = PSC_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_m1    <= MIN_DIV_M1;
      gap_len   <= '0;
      late      <= 1'b0;
      addr_bits <= (SIZE_W+1)'(1);
    end else if (load) begin
      // a divisor of one cannot be produced by a registered clock
      div_m1    <= (cfg_psc == '0) ? MIN_DIV_M1 : cfg_psc;
      gap_len   <= cfg_gap;
      late      <= cfg_late;
      addr_bits <= {1'b0, cfg_size} + (SIZE_W+1)'(1);
    end
  end
endmodule

// File: rtl/qspi_sck_gen.sv
module qspi_sck_gen #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSC_W-1:0] div_m1,
  input  logic             restart,
  input  logic             drive,
  input  logic             late,
  output logic             wrap,
  output logic             sck,
  output logic             sample_stb
);
  localparam int CW = PSC_W + 1;

  logic [PSC_W-1:0] ph, ph_n;
  logic [CW-1:0]    div, hi_len, lo_len;
  logic             sck_n, rise_n, fall_n;

  assign div    = {1'b0, div_m1} + CW'(1);
  assign hi_len = div >> 1;
  assign lo_len = div - hi_len;
  assign wrap   = (ph == div_m1);

  always_comb begin
    if (restart || wrap) ph_n = '0;
    else                 ph_n = ph + PSC_W'(1);
    sck_n  = drive && ({1'b0, ph_n} >= lo_len);
    rise_n = !sck && sck_n;
    fall_n = sck && !sck_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= '0;
      sck        <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      ph         <= ph_n;
      sck        <= sck_n;
      sample_stb <= drive && (late ? fall_n : rise_n);
    end
  end
endmodule

// File: rtl/qspi_gap_cnt.sv
module qspi_gap_cnt #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [GAP_W-1:0] gap_len,
  output logic             gap_over
);
  logic [GAP_W-1:0] periods;
  logic [GAP_W:0]   after_tick;

  assign after_tick = {1'b0, periods} + (GAP_W+1)'(1);
  assign gap_over   = (gap_len == '0) || (tick && (after_tick >= {1'b0, gap_len}));

  always_ff @(posedge clk) begin
    if (rst || clear) periods <= '0;
    else if (tick)    periods <= periods + GAP_W'(1);
  end
endmodule

// File: rtl/qspi_sck_timing.sv
module qspi_sck_timing
  import qspi_tim_pkg::*;
#(
  parameter int PSC_W  = 8,
  parameter int GAP_W  = 4,
  parameter int SIZE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              seq_done,
  input  logic [PSC_W-1:0]  cfg_psc,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              cfg_late,
  output logic              sck,
  output logic              csn,
  output logic              sample_stb,
  output logic              busy,
  output logic [SIZE_W:0]   addr_bits
);
  tim_state_t       state, state_n;
  logic             pend, restart, wrap, gap_over, drive;
  logic [PSC_W-1:0] div_m1;
  logic [GAP_W-1:0] gap_len;
  logic             late;

  qspi_cfg_shadow #(.PSC_W(PSC_W), .GAP_W(GAP_W), .SIZE_W(SIZE_W)) u_shadow (
    .clk(clk), .rst(rst), .load(state == ST_IDLE),
    .cfg_psc(cfg_psc), .cfg_gap(cfg_gap), .cfg_size(cfg_size), .cfg_late(cfg_late),
    .div_m1(div_m1), .gap_len(gap_len), .late(late), .addr_bits(addr_bits)
  );

  qspi_sck_gen #(.PSC_W(PSC_W)) u_sck (
    .clk(clk), .rst(rst), .div_m1(div_m1), .restart(restart), .drive(drive),
    .late(late), .wrap(wrap), .sck(sck), .sample_stb(sample_stb)
  );

  qspi_gap_cnt #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst(rst), .clear(restart), .tick(wrap && (state == ST_GAP)),
    .gap_len(gap_len), .gap_over(gap_over)
  );

  always_comb begin
    state_n = state;
    restart = 1'b0;
    unique case (state)
      ST_IDLE: if (start_req || pend) begin
        state_n = ST_RUN;
        restart = 1'b1;
      end
      ST_RUN: if (seq_done && wrap) begin
        state_n = ST_GAP;
        restart = 1'b1;
      end
      ST_GAP: if (gap_over) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  assign drive = (state_n == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
      csn   <= 1'b1;
      busy  <= 1'b0;
    end else begin
      state <= state_n;
      if (state == ST_IDLE) pend <= 1'b0;
      else if (start_req)   pend <= 1'b1;
      csn   <= (state_n != ST_RUN);
      busy  <= (state_n != ST_IDLE);
    end
  end
endmodule

// File: rtl/qspi_sck_timing_chk.sv
module qspi_sck_timing_chk #(
  parameter int SIZE_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            sck,
  input logic            csn,
  input logic            sample_stb,
  input logic            busy,
  input logic [SIZE_W:0] addr_bits
);
  logic [1:0] hi_run;
  logic       seen_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run   <= '0;
      seen_low <= 1'b0;
    end else begin
      if (!csn)               hi_run <= '0;
      else if (hi_run != 2'd3) hi_run <= hi_run + 2'd1;
      if (!csn) seen_low <= 1'b1;
    end
  end

  p_sck_idle_r3: assert property (@(posedge clk) disable iff (rst) csn |-> !sck);

  // covers R8 as well: a strobe only ever sits on an SCK transition
  p_stb_edge_r7: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (!csn && (sck != $past(sck))));

  p_busy_cover_r6: assert property (@(posedge clk) disable iff (rst) !csn |-> busy);

  p_gap_min_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(csn) && seen_low) |-> (hi_run >= 2'd2));

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!csn && !$past(csn)) |-> $stable(addr_bits));

  p_addr_range_r9: assert property (@(posedge clk) disable iff (rst)
    (addr_bits != '0) && (int'(addr_bits) <= (1 << SIZE_W)));
endmodule

bind qspi_sck_timing qspi_sck_timing_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst(rst), .sck(sck), .csn(csn), .sample_stb(sample_stb),
  .busy(busy), .addr_bits(addr_bits)
);

// File: tb/qspi_sck_timing_test.sv
module qspi_sck_timing_test;
  localparam int PSC_W  = 8;
  localparam int GAP_W  = 4;
  localparam int SIZE_W = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic start_req = 1'b0, seq_done = 1'b0, cfg_late = 1'b0;
  logic [PSC_W-1:0]  cfg_psc = '0;
  logic [GAP_W-1:0]  cfg_gap = '0;
  logic [SIZE_W-1:0] cfg_size = '0;
  logic sck, csn, sample_stb, busy;
  logic [SIZE_W:0] addr_bits;

  qspi_sck_timing #(.PSC_W(PSC_W), .GAP_W(GAP_W), .SIZE_W(SIZE_W)) uut (
    .clk(clk), .rst(rst), .start_req(start_req), .seq_done(seq_done),
    .cfg_psc(cfg_psc), .cfg_gap(cfg_gap), .cfg_size(cfg_size), .cfg_late(cfg_late),
    .sck(sck), .csn(csn), .sample_stb(sample_stb), .busy(busy), .addr_bits(addr_bits)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit mon_on = 0, have_last = 0, pend_flag = 0, have_rise = 0, seq_late = 0, done_run = 0;
  int seq_div = 2, seq_gap = 0, seq_size = 0, exp_nper = 0;
  int last_gap = 0, last_div = 2, rise_cnt = 0, since_rise = 0, hi_run = 0;
  logic prev_sck = 1'b0, prev_csn = 1'b1, rise, fall, exp_stb;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic int div_of(input int p);
    return (p == 0) ? 2 : p + 1;
  endfunction

  function automatic int exact_gap(input int g, input int d);
    return (g == 0) ? 2 : g * d + 1;
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      if (csn) chk(sck == 1'b0, "R3 sck idle", sck, 0);
      rise    = sck && !prev_sck;
      fall    = !sck && prev_sck && !csn;
      exp_stb = !csn && (seq_late ? fall : rise);
      chk(sample_stb == exp_stb, seq_late ? "R8 late strobe" : "R7 strobe", sample_stb, exp_stb);
      if (!csn) chk(int'(addr_bits) == seq_size + 1, "R9 R10 addr_bits", addr_bits, seq_size + 1);
      if (!csn && prev_csn) begin
        chk(sck == 1'b0, "R3 first low cycle", sck, 0);
        if (have_last) begin
          chk(hi_run >= last_gap * last_div, "R5 gap min", hi_run, last_gap * last_div);
          if (pend_flag)
            chk(hi_run == exact_gap(last_gap, last_div), "R6 held start",
                hi_run, exact_gap(last_gap, last_div));
        end
        rise_cnt = 0; have_rise = 0; pend_flag = 0;
      end
      if (fall) chk(since_rise == seq_div / 2, "R2 high phase", since_rise, seq_div / 2);
      if (rise && !csn) begin
        if (have_rise) chk(since_rise == seq_div, "R2 period", since_rise, seq_div);
        have_rise = 1; since_rise = 0; rise_cnt++;
      end
      since_rise++;
      if (csn && !prev_csn) begin
        chk(rise_cnt == exp_nper, "R4 edge count", rise_cnt, exp_nper);
        last_gap = seq_gap; last_div = seq_div; have_last = 1;
      end
      if (csn) hi_run++; else hi_run = 0;
      prev_sck = sck;
      prev_csn = csn;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_run) begin
      done_run = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run_seq(input int p, input int g, input int s, input bit l,
                         input int nper, input bit early);
    if (!early) while (busy) step();
    cfg_psc = PSC_W'(p); cfg_gap = GAP_W'(g); cfg_size = SIZE_W'(s); cfg_late = l;
    seq_div = div_of(p); seq_gap = g; seq_size = s; seq_late = l; exp_nper = nper;
    if (busy) pend_flag = 1;
    start_req = 1'b1;
    step();
    start_req = 1'b0;
    while (csn) step();
    // R10: scramble configuration while the sequence runs
    cfg_psc = PSC_W'($urandom); cfg_gap = GAP_W'($urandom);
    cfg_size = SIZE_W'($urandom); cfg_late = 1'($urandom);
    while (rise_cnt < nper) step();
    seq_done = 1'b1;
    while (!csn) step();
    seq_done = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) begin
      step();
      chk(csn == 1'b1 && sck == 1'b0 && sample_stb == 1'b0 && busy == 1'b0,
          "R1 reset state", {csn, sck, sample_stb, busy}, 4'b1000);
    end
    rst = 1'b0;
    step();
    chk(csn == 1'b1 && sck == 1'b0 && busy == 1'b0, "R1 after reset", {csn, sck, busy}, 3'b100);
    mon_on = 1;
    run_seq(1, 0, 31, 0, 3, 0);
    run_seq(0, 2, 0, 1, 2, 1);
    run_seq(2, 3, 23, 0, 4, 1);
    run_seq(200, 1, 15, 1, 2, 0);
    run_seq(7, 15, 7, 1, 3, 1);
    run_seq(3, 0, 9, 1, 1, 1);
    for (int i = 0; i < 30; i++)
      run_seq($urandom_range(0, 12), $urandom_range(0, 6), $urandom_range(0, 31),
              1'($urandom), $urandom_range(1, 5), 1'($urandom));
    while (busy) step();
    repeat (4) step();
    if (!done_run) begin
      done_run = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule